// File: doc/BRIEF.md
# Per-CPU level interrupt aggregator

This block collects a parameterised set of level-sensitive peripheral interrupt lines and presents them to several CPUs. Every CPU owns a complete bank of registers: one enable word and one status word per group of 32 lines. Software picks which lines reach which CPU by setting bits in that CPU's enable words, so any line can go to any subset of CPUs. Each bank drives a single active-high interrupt output toward its CPU.

The inputs are asynchronous and pass through a two-flop synchroniser. A status bit shows the synchronised line level masked by the matching enable bit. Nothing is latched, so a source is cleared at the peripheral. A CPU's interrupt output is the registered OR of its status bits. There is no priority encoder and no pending queue: software reads all status words of its bank to find the active sources. The enable words have no set-bit or clear-bit aliases, so a change to one bit needs a full-word write.

Top module: `lvl_irq_router`

## Requirements
- R1: `NUM_LINES` must be 32, 64 or 128. Each bank holds `WPT = NUM_LINES/32` enable words and `WPT` status words. Bit k of word w refers to line 32*w+k.
- R2: `reg_addr` is a byte address and bits [1:0] are ignored. Bank c starts at byte c*8*WPT. Enable word w is at bank base + 4*w. Status word w is at bank base + 4*(WPT+w).
- R3: Enable words are plain full-word read/write registers. A read returns the last value written to that word. The read data on `reg_rdata` is combinational from `reg_addr`.
- R4: A status word reads as the synchronised line levels ANDed with the same bank's enable word. A write to a status word has no effect.
- R5: The banks are independent. A write to one bank leaves every other bank's enables, status and output unchanged.
- R6: `irq_out[c]` is the registered OR of bank c's status bits. A line change driven before rising edge k shows on the output after edge k+2. An enable write committed at edge k shows on the output after edge k+1.
- R7: An address whose bank index is NUM_CPUS or greater reads as zero, and a write to it has no effect.
- R8: While `rst_n` is low, every enable bit is zero and every `irq_out` is low.
- R9: Interrupts are level-sensitive. An enabled line held high keeps its status bit and its CPU output high, however many reads take place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_LINES | Level-sensitive peripheral interrupt lines (asynchronous) |
| reg_addr | input | ADDR_W | Register byte address |
| reg_we | input | 1 | Write strobe, one word per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_out | output | NUM_CPUS | One interrupt request per CPU |

## Verification
The bench builds the block with 64 lines and 3 CPUs. With these values each bank has two enable words and two status words, so routing across words can be tested, and the bank stride of 16 bytes is not simply one word. Because 3 is not a power of two, bank index 3 is a real address with no bank behind it, which lets the bench test the out-of-range reads and ignored writes. Randomly generated enable patterns and line patterns are checked against a reference model of the masking in the bench. Directed cases then count the clock edges of the input-to-output latency and the enable-to-output latency.

// File: rtl/lvl_irq_router.sv
module lvl_irq_router #(
  parameter int NUM_LINES = 64,
  parameter int NUM_CPUS  = 2,
  parameter int ADDR_W    = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_we,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic [NUM_CPUS-1:0]  irq_out
);
  localparam int WPT    = NUM_LINES / 32;
  localparam int WSEL   = $clog2(2 * WPT);
  localparam int BANK_W = ADDR_W - 2 - WSEL;
  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NUM_CPUS - 1);

  if (NUM_LINES != 32 && NUM_LINES != 64 && NUM_LINES != 128) begin : g_bad_lines
    $error("NUM_LINES must be 32, 64 or 128");
  end

  logic [NUM_LINES-1:0] sync1, sync2;
  logic [NUM_CPUS-1:0][NUM_LINES-1:0] en_q;
  logic [NUM_CPUS-1:0][NUM_LINES-1:0] stat;

  wire [WSEL-1:0]   slot      = reg_addr[2 +: WSEL];
  wire [BANK_W-1:0] bank      = reg_addr[ADDR_W-1 -: BANK_W];
  wire              bank_ok   = bank <= LAST_BANK;
  wire              is_status = slot >= WSEL'(WPT);
  wire [WSEL-1:0]   widx      = is_status ? slot - WSEL'(WPT) : slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= irq_in;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (reg_we && bank_ok && !is_status) begin
      for (int c = 0; c < NUM_CPUS; c++)
        if (bank == BANK_W'(c))
          en_q[c][{widx, 5'b0} +: 32] <= reg_wdata;
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_CPUS; c++)
      stat[c] = sync2 & en_q[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_out <= '0;
    end else begin
      for (int c = 0; c < NUM_CPUS; c++)
        irq_out[c] <= |stat[c];
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int c = 0; c < NUM_CPUS; c++)
      if (bank_ok && bank == BANK_W'(c))
        reg_rdata = is_status ? stat[c][{widx, 5'b0} +: 32]
                              : en_q[c][{widx, 5'b0} +: 32];
  end
endmodule

// File: rtl/lvl_irq_router_chk.sv
module lvl_irq_router_chk #(
  parameter int NUM_LINES = 64,
  parameter int NUM_CPUS  = 2,
  parameter int ADDR_W    = 12
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic [NUM_LINES-1:0]               irq_in,
  input logic [ADDR_W-1:0]                  reg_addr,
  input logic                               reg_we,
  input logic [NUM_CPUS-1:0]                irq_out,
  input logic [NUM_CPUS-1:0][NUM_LINES-1:0] en_q
);
  localparam int WPT = NUM_LINES / 32;

  wire [ADDR_W-1:0] word_no  = reg_addr >> 2;
  wire              st_hit   = (int'(word_no) % (2 * WPT)) >= WPT;
  wire              far_bank = (int'(word_no) / (2 * WPT)) >= NUM_CPUS;

  // R8
  assert_reset_clear_R8: assert property (@(posedge clk)
    !rst_n |-> (irq_out == '0 && en_q == '0));

  // R4
  assert_status_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && st_hit) |=> $stable(en_q));

  // R7
  assert_far_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && far_bank) |=> $stable(en_q));

  // R6
  assert_quiet_lines_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_in, 3) == '0 && $past(irq_in, 2) == '0) |-> (irq_out == '0));

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    // R6
    assert_rise_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_out[c]) |-> $past(en_q[c] != '0));
    // R5
    assert_masked_bank_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[c] == '0 && $past(en_q[c] == '0)) |-> !irq_out[c]);
  end
endmodule

bind lvl_irq_router lvl_irq_router_chk #(
  .NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
  .reg_we(reg_we), .irq_out(irq_out), .en_q(en_q)
);

// File: tb/lvl_irq_router_test.sv
module lvl_irq_router_test;
  localparam int NL  = 64;
  localparam int NC  = 3;
  localparam int AW  = 12;
  localparam int WPT = NL / 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic [NL-1:0] irq_in = '0;
  logic [AW-1:0] reg_addr = '0;
  logic          reg_we = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NC-1:0] irq_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [NL-1:0] en_m [NC];

  lvl_irq_router #(.NUM_LINES(NL), .NUM_CPUS(NC), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  always #2 clk = ~clk;

  function automatic int addr_of(int cpu, bit st, int w);
    return cpu * 8 * WPT + ((st ? WPT : 0) + w) * 4;
  endfunction

  function automatic logic [31:0] exp_status(int cpu, int w);
    return irq_in[w*32 +: 32] & en_m[cpu][w*32 +: 32];
  endfunction

  function automatic logic [NC-1:0] exp_out();
    logic [NC-1:0] r;
    for (int c = 0; c < NC; c++) r[c] = |(irq_in & en_m[c]);
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    reg_addr = AW'(a);
    reg_wdata = d;
    reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic set_en(int cpu, int w, logic [31:0] d);
    wr(addr_of(cpu, 0, w), d);
    en_m[cpu][w*32 +: 32] = d;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = AW'(a);
    #1 d = reg_rdata;
  endtask

  task automatic check_all(string tag);
    logic [31:0] d;
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < WPT; w++) begin
        rd(addr_of(c, 0, w), d);
        chk({tag, " R3 enable readback"}, d, en_m[c][w*32 +: 32]);
        rd(addr_of(c, 1, w), d);
        chk({tag, " R4 status"}, d, exp_status(c, w));
      end
    chk({tag, " R6 irq_out"}, 32'(irq_out), 32'(exp_out()));
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd915));
    for (int c = 0; c < NC; c++) en_m[c] = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 irq_out in reset", 32'(irq_out), 32'd0);
    rst_n = 1'b1;
    check_all("R8 after reset");

    // R1 R2 word and bit placement: line 32*w+k maps to bit k of word w
    set_en(2, 1, 32'h0000_0100);
    @(negedge clk);
    irq_in[40] = 1'b1;
    repeat (4) @(negedge clk);
    rd(addr_of(2, 1, 1), d);
    chk("R1 R2 line 40 in status word 1 bit 8", d, 32'h0000_0100);
    rd(addr_of(2, 1, 0), d);
    chk("R2 status word 0 clear", d, 32'd0);
    chk("R2 cpu2 output", 32'(irq_out), 32'b100);
    irq_in = '0;
    set_en(2, 1, 32'd0);
    repeat (4) @(negedge clk);

    // R6 latency from the input
    set_en(0, 0, 32'h0000_0020);
    @(negedge clk);
    irq_in[5] = 1'b1;
    @(negedge clk);
    chk("R6 out after edge 1", 32'(irq_out[0]), 32'd0);
    @(negedge clk);
    chk("R6 out after edge 2", 32'(irq_out[0]), 32'd0);
    @(negedge clk);
    chk("R6 out after edge 3", 32'(irq_out[0]), 32'd1);

    // R9 level is held through reads
    for (int i = 0; i < 3; i++) begin
      rd(addr_of(0, 1, 0), d);
      chk("R9 status held", d, 32'h0000_0020);
    end
    chk("R9 output held", 32'(irq_out[0]), 32'd1);

    // R6 latency from an enable clear; R5 other banks
    set_en(0, 0, 32'd0);
    chk("R6 out right after write edge", 32'(irq_out[0]), 32'd1);
    @(negedge clk);
    chk("R6 out one edge later", 32'(irq_out[0]), 32'd0);
    chk("R5 other cpus quiet", 32'(irq_out[2:1]), 32'd0);
    irq_in = '0;

    // R4 status writes ignored
    set_en(1, 0, 32'h00ff_00ff);
    wr(addr_of(1, 1, 0), 32'hffff_ffff);
    rd(addr_of(1, 0, 0), d);
    chk("R4 status write left enable", d, 32'h00ff_00ff);
    rd(addr_of(1, 1, 0), d);
    chk("R4 status write left status", d, 32'd0);

    // R7 bank beyond NUM_CPUS
    wr(addr_of(NC, 0, 0), 32'hdead_beef);
    rd(addr_of(NC, 0, 0), d);
    chk("R7 far bank reads zero", d, 32'd0);
    check_all("R7 banks intact");

    // R3 low address bits ignored
    wr(addr_of(0, 0, 1) + 3, 32'h1234_5678);
    en_m[0][63:32] = 32'h1234_5678;
    rd(addr_of(0, 0, 1) + 1, d);
    chk("R3 R2 low bits ignored", d, 32'h1234_5678);

    // R5 independent random routing
    for (int it = 0; it < 40; it++) begin
      for (int k = 0; k < 2; k++)
        set_en(int'($urandom % NC), int'($urandom % WPT), $urandom & $urandom);
      @(negedge clk);
      irq_in = {$urandom, $urandom};
      repeat (4) @(negedge clk);
      check_all("R5 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule